// File: doc/BRIEF.md
# Memory Self-Test Sequencer

This block runs a memory check once reset is released and shows its progress on a two-bit stage code meant for a pair of status LEDs. A wait indicator is lit first for a long hold period, a parameterized number of clock cycles (tens of seconds at board clock rates, a few cycles in simulation). The sequencer then drives a generic synchronous memory request port through two passes over the whole address range. In the first pass it writes and reads back each address in turn. In the second pass it reads every address again, which exposes address aliasing that the first pass cannot see.

The stored value at each address is a function of that address, so two addresses that collide in the memory leave a visible difference. When a comparison fails, the sequencer stops issuing requests. It latches the pass that failed and the lowest data bit that differed, and holds them until the next reset. A clean run ends with the stage code showing completion.

Top module: `memtest_seq`

## Requirements
- R1: After reset is released, `hold_led` stays 1 for exactly HOLD_CYCLES rising clock edges and then goes to 0. No write or read request is issued while `hold_led` is 1.
- R2: While reset is asserted and during the hold period, `stage_code` is 2'b00, `err_flag` is 0, and `mem_we` and `mem_rd` are 0.
- R3: During the first pass, `stage_code` is 2'b01. For each address from 0 up to 2**ADDR_W-1, the sequencer issues one write, then one read of the same address. The written value is the address, zero-extended with address bit i on data bit i, XOR PAT_KEY.
- R4: During the second pass, `stage_code` is 2'b10. The sequencer reads every address from 0 upward, once each, and compares each result with the value from R3.
- R5: After both passes complete with no mismatch, `stage_code` is 2'b11 and `err_flag` is 0, and no further requests are issued.
- R6: On the first mismatch, `err_flag` becomes 1 and `err_stage` shows the failing pass: 2'b01 for the first pass or 2'b10 for the second.
- R7: On a mismatch, `err_bit` holds the lowest bit index at which the returned data differs from the expected value.
- R8: After a mismatch, no further requests are issued. `stage_code` stays at the failing pass's code, and `err_flag`, `err_stage` and `err_bit` hold until reset.
- R9: Asserting reset clears the error outputs and restarts the hold period and the whole test.
- R10: A read result is accepted whenever `mem_rvalid` arrives, one or more cycles after the read strobe. The sequencer issues nothing new while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_we | output | 1 | Write strobe, one cycle per write |
| mem_rd | output | 1 | Read strobe, one cycle per read |
| mem_rdata | input | DATA_W | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data valid |
| hold_led | output | 1 | Start-up hold indicator |
| stage_code | output | 2 | Stage code: 00 hold, 01 write/read pass, 10 verify pass, 11 done |
| err_flag | output | 1 | Mismatch seen |
| err_stage | output | 2 | Stage code of the failing pass |
| err_bit | output | $clog2(DATA_W) | Lowest mismatching bit index |

## Verification
The assertions assume that the memory raises `mem_rvalid` exactly once for each read strobe, and never while no read is outstanding. They also assume that the memory accepts every write strobe in the cycle it is issued. The bench's memory model meets these assumptions for any read latency from one to four cycles. Faults are injected only by altering the data or address the model uses, and never by adding or dropping responses. This keeps the handshake legal while the compared data goes wrong in a chosen pass, at a chosen address and bit.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

   typedef enum logic [2:0] {
      ST_HOLD  = 3'd0,
      ST_P1_WR = 3'd1,
      ST_P1_RD = 3'd2,
      ST_P1_WT = 3'd3,
      ST_P2_RD = 3'd4,
      ST_P2_WT = 3'd5,
      ST_DONE  = 3'd6,
      ST_FAIL  = 3'd7
   } seq_state_t;

   localparam logic [1:0] CODE_HOLD = 2'b00;
   localparam logic [1:0] CODE_P1   = 2'b01;
   localparam logic [1:0] CODE_P2   = 2'b10;
   localparam logic [1:0] CODE_DONE = 2'b11;

endpackage

// File: rtl/mt_hold_timer.sv
module mt_hold_timer #(
   parameter longint unsigned HOLD_CYCLES = 64'd20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(HOLD_CYCLES) + 1;

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign expired = run && (cnt_q == CW'(HOLD_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run && !expired)
         cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(HOLD_CYCLES)); // R1

endmodule

// File: rtl/mt_pattern_gen.sv
module mt_pattern_gen #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] PAT_KEY = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] pat
);
   generate
      if (DATA_W >= ADDR_W) begin : g_wide
         assign pat = DATA_W'(addr) ^ PAT_KEY;
      end else begin : g_narrow
         assign pat = addr[DATA_W-1:0] ^ PAT_KEY;
      end
   endgenerate
endmodule

// File: rtl/mt_low_bit.sv
module mt_low_bit #(
   parameter int DATA_W = 8,
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic [DATA_W-1:0] diff,
   output logic              any,
   output logic [BIT_W-1:0]  idx
);
   assign any = |diff;

   always_comb begin
      idx = '0;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         if (diff[i]) idx = BIT_W'(i);
      end
   end
endmodule

// File: rtl/memtest_seq.sv
module memtest_seq
   import memtest_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] PAT_KEY = DATA_W'(8'hA5),
   parameter longint unsigned HOLD_CYCLES = 64'd5_000_000_000,
   localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic              hold_led,
   output logic [1:0]        stage_code,
   output logic              err_flag,
   output logic [1:0]        err_stage,
   output logic [BIT_W-1:0]  err_bit
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              err_q, err_d;
   logic [1:0]        err_stage_q, err_stage_d;
   logic [BIT_W-1:0]  err_bit_q, err_bit_d;
   logic              hold_done;
   logic [DATA_W-1:0] expect_w, diff_w;
   logic              miss_w;
   logic [BIT_W-1:0]  miss_idx;
   logic              waiting;

   mt_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_HOLD),
      .expired (hold_done)
   );

   mt_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_KEY(PAT_KEY)) u_pat (
      .addr (addr_q),
      .pat  (expect_w)
   );

   assign diff_w = mem_rdata ^ expect_w;

   mt_low_bit #(.DATA_W(DATA_W)) u_low (
      .diff (diff_w),
      .any  (miss_w),
      .idx  (miss_idx)
   );

   assign waiting = (state_q == ST_P1_WT) || (state_q == ST_P2_WT);

   always_comb begin
      state_d     = state_q;
      addr_d      = addr_q;
      err_d       = err_q;
      err_stage_d = err_stage_q;
      err_bit_d   = err_bit_q;
      unique case (state_q)
         ST_HOLD:  if (hold_done) begin
                      state_d = ST_P1_WR;
                      addr_d  = '0;
                   end
         ST_P1_WR: state_d = ST_P1_RD;
         ST_P1_RD: state_d = ST_P1_WT;
         ST_P2_RD: state_d = ST_P2_WT;
         ST_P1_WT, ST_P2_WT: begin
            if (mem_rvalid) begin
               if (miss_w) begin
                  state_d     = ST_FAIL;
                  err_d       = 1'b1;
                  err_stage_d = (state_q == ST_P1_WT) ? CODE_P1 : CODE_P2;
                  err_bit_d   = miss_idx;
               end else if (addr_q == LAST_ADDR) begin
                  addr_d  = '0;
                  state_d = (state_q == ST_P1_WT) ? ST_P2_RD : ST_DONE;
               end else begin
                  addr_d  = addr_q + 1'b1;
                  state_d = (state_q == ST_P1_WT) ? ST_P1_WR : ST_P2_RD;
               end
            end
         end
         ST_DONE:  state_d = ST_DONE;
         ST_FAIL:  state_d = ST_FAIL;
         default:  state_d = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_HOLD;
         addr_q      <= '0;
         err_q       <= 1'b0;
         err_stage_q <= CODE_HOLD;
         err_bit_q   <= '0;
      end else begin
         state_q     <= state_d;
         addr_q      <= addr_d;
         err_q       <= err_d;
         err_stage_q <= err_stage_d;
         err_bit_q   <= err_bit_d;
      end
   end

   assign mem_addr  = addr_q;
   assign mem_wdata = expect_w;
   assign mem_we    = (state_q == ST_P1_WR);
   assign mem_rd    = (state_q == ST_P1_RD) || (state_q == ST_P2_RD);
   assign hold_led  = (state_q == ST_HOLD);
   assign err_flag  = err_q;
   assign err_stage = err_stage_q;
   assign err_bit   = err_bit_q;

   always_comb begin
      unique case (state_q)
         ST_HOLD:                     stage_code = CODE_HOLD;
         ST_P1_WR, ST_P1_RD, ST_P1_WT: stage_code = CODE_P1;
         ST_P2_RD, ST_P2_WT:          stage_code = CODE_P2;
         ST_DONE:                     stage_code = CODE_DONE;
         default:                     stage_code = err_stage_q;
      endcase
   end

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hold_led |-> (!mem_we && !mem_rd)); // R1
   AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      hold_led |-> (stage_code == CODE_HOLD && !err_flag)); // R2
   AST_WR_THEN_RD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (mem_rd && $stable(mem_addr) && stage_code == CODE_P1)); // R3
   AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_code == CODE_DONE) |-> (!err_flag && !mem_we && !mem_rd)); // R5
   AST_ERR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> (err_stage == CODE_P1 || err_stage == CODE_P2)); // R6
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> (err_flag && $stable(err_stage) && $stable(err_bit)
                    && $stable(stage_code))); // R8
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> (!mem_we && !mem_rd)); // R8
   AST_RVALID_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> waiting); // R10
   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> (!mem_rd && !mem_we)); // R10

endmodule

// File: tb/sim_memtest_seq.sv
module sim_memtest_seq;
   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int HOLD   = 20;
   localparam logic [DATA_W-1:0] KEY = 8'hA5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_wdata, mem_rdata;
   logic mem_we, mem_rd, mem_rvalid, hold_led, err_flag;
   logic [1:0] stage_code, err_stage;
   logic [2:0] err_bit;

   memtest_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAT_KEY(KEY),
                 .HOLD_CYCLES(64'(HOLD))) u0 (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid), .hold_led(hold_led), .stage_code(stage_code),
      .err_flag(err_flag), .err_stage(err_stage), .err_bit(err_bit));

   int nchk = 0, nfail = 0;

   // fault controls
   int lat = 1;
   logic alias_en = 0, flt_en = 0, flt_p2 = 0;
   logic [ADDR_W-1:0] flt_addr = '0;
   logic [DATA_W-1:0] flt_xor = '0;

   // monitor (negedge)
   int wr_cnt, rd_cnt, hold_req, post_err_req;
   logic seq_bad;
   always @(negedge clk) begin
      if (!rst_n) begin
         wr_cnt = 0; rd_cnt = 0; hold_req = 0; post_err_req = 0; seq_bad = 0;
      end else begin
         if ((mem_we || mem_rd) && hold_led) hold_req++;
         if ((mem_we || mem_rd) && err_flag) post_err_req++;
         if (mem_we) begin
            if (mem_addr != ADDR_W'(wr_cnt) || mem_wdata != (DATA_W'(mem_addr) ^ KEY)
                || stage_code != 2'b01) seq_bad = 1;
            wr_cnt++;
         end
         if (mem_rd) begin
            if (rd_cnt < DEPTH) begin
               if (mem_addr != ADDR_W'(rd_cnt) || wr_cnt != rd_cnt + 1 || stage_code != 2'b01)
                  seq_bad = 1;
            end else if (mem_addr != ADDR_W'(rd_cnt - DEPTH) || stage_code != 2'b10)
               seq_bad = 1;
            rd_cnt++;
         end
      end
   end

   // behavioural RAM with variable latency and fault injection
   logic [DATA_W-1:0] ram [DEPTH];
   logic [3:0] pv;
   logic [DATA_W-1:0] pd [4];
   function automatic logic [ADDR_W-1:0] map_a(input logic [ADDR_W-1:0] a);
      return alias_en ? (a & ~(ADDR_W'(1) << (ADDR_W - 1))) : a;
   endfunction
   always @(posedge clk) begin
      logic [DATA_W-1:0] d;
      if (mem_we) ram[map_a(mem_addr)] <= mem_wdata;
      d = ram[map_a(mem_addr)];
      if (flt_en && mem_addr == flt_addr && (!flt_p2 || rd_cnt > DEPTH)) d = d ^ flt_xor;
      pv <= {pv[2:0], mem_rd && rst_n};
      pd[0] <= d; pd[1] <= pd[0]; pd[2] <= pd[1]; pd[3] <= pd[2];
   end
   assign mem_rvalid = pv[lat-1];
   assign mem_rdata  = pd[lat-1];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk); rst_n = 0;
      repeat (3) @(negedge clk);
      check(stage_code == 2'b00 && hold_led && !err_flag, "R9", int'(err_flag), 0);
      check(!mem_we && !mem_rd, "R2", int'({mem_we, mem_rd}), 0);
   endtask

   task automatic release_and_hold();
      int n = 0;
      rst_n = 1;
      forever begin
         @(posedge clk); n++;
         @(negedge clk);
         if (!hold_led || n > HOLD + 5) break;
         if (stage_code != 2'b00) begin check(0, "R2", int'(stage_code), 0); end
      end
      check(n == HOLD, "R1", n, HOLD);
      check(hold_req == 0, "R1", hold_req, 0);
   endtask

   task automatic wait_end();
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (stage_code == 2'b11 || err_flag) break;
      end
   endtask

   task automatic test_reset_state();
      apply_reset();
      check(stage_code == 2'b00, "R2", int'(stage_code), 0);
      check(hold_led == 1, "R2", int'(hold_led), 1);
   endtask

   task automatic test_clean(input int l);
      int w, r;
      lat = l; alias_en = 0; flt_en = 0;
      apply_reset();
      release_and_hold();
      wait_end();
      check(stage_code == 2'b11, "R5", int'(stage_code), 3);
      check(!err_flag, "R5", int'(err_flag), 0);
      check(wr_cnt == DEPTH, "R3", wr_cnt, DEPTH);
      check(rd_cnt == 2 * DEPTH, "R4", rd_cnt, 2 * DEPTH);
      check(!seq_bad, l > 1 ? "R10" : "R3", int'(seq_bad), 0);
      w = wr_cnt; r = rd_cnt;
      repeat (20) @(negedge clk);
      check(wr_cnt == w && rd_cnt == r && stage_code == 2'b11, "R5", rd_cnt, r);
   endtask

   task automatic test_fault(input string tag, input logic p2, input logic al,
                             input logic [ADDR_W-1:0] fa, input logic [DATA_W-1:0] fx,
                             input int exp_stage, input int exp_bit, input int exp_rd);
      int r;
      lat = 2; alias_en = al; flt_en = !al; flt_p2 = p2; flt_addr = fa; flt_xor = fx;
      apply_reset();
      release_and_hold();
      wait_end();
      check(err_flag, "R6", int'(err_flag), 1);
      check(int'(err_stage) == exp_stage, "R6", int'(err_stage), exp_stage);
      check(int'(err_bit) == exp_bit, "R7", int'(err_bit), exp_bit);
      check(rd_cnt == exp_rd, {"R8 ", tag}, rd_cnt, exp_rd);
      r = rd_cnt;
      repeat (30) @(negedge clk);
      check(rd_cnt == r && post_err_req == 0, "R8", post_err_req, 0);
      check(int'(stage_code) == exp_stage && err_flag && int'(err_bit) == exp_bit,
            "R8", int'(stage_code), exp_stage);
      alias_en = 0; flt_en = 0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      test_reset_state();
      test_clean(1);
      test_clean(3);
      test_fault("p1", 0, 0, 4'd6, 8'h28, 1, 3, 7);
      test_fault("alias", 0, 1, 4'd0, 8'h00, 2, 3, DEPTH + 1);
      test_fault("p2", 1, 0, 4'd15, 8'h81, 2, 0, 2 * DEPTH);
      test_fault("msb", 0, 0, 4'd0, 8'h80, 1, 7, 1);
      test_clean(4);
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule